// File: doc/BRIEF.md
# Sensor Configuration Table Register Slave

This block is a 32-bit AXI4-Lite slave that lets a processor fill a 256-entry sensor setup table and steer two control outputs. Every entry pairs an 8-bit sensor register address with the 8-bit value to load into it. A configuration sequencer, such as an I2C engine outside this block, walks the table through a dedicated synchronous read port. The sequencer is not part of this block.

Software loads one entry per bus write. It does this by writing a single word to the table-load register. That word carries the destination slot in one byte and the 16-bit entry in the two bytes below it, so no separate index register is needed. A second register holds a restart request for the sequencer. A third register selects the pixel colour format, and its low three bits feed the pixel decoder directly. All outputs come from flops.

Top module: `sensor_cfg_slave`

## Requirements
- R1: After a synchronous active-high reset, all three registers read as zero. `seq_restart` and `pix_fmt_sel` are 0, and `s_bvalid` and `s_rvalid` are low.
- R2: A write to offset 0x00 that has strobes 0, 1 and 2 all set stores `wdata[15:0]` into table slot `wdata[23:16]`. In the stored entry, bits [15:8] are the sensor register address and bits [7:0] are its value. Bits [31:24] have no effect on the table.
- R3: A write to offset 0x00 with any of strobes 0 to 2 cleared changes neither the table nor the value read back from offset 0x00.
- R4: Each accepted offset-0x00 write produces a table write enable that is high for exactly one clock cycle. Writing a slot leaves other slots unchanged, and the last write to a slot wins.
- R5: Bit 0 of the register at offset 0x04 drives `seq_restart`, active high. Bits [2:0] of the register at offset 0x08 drive `pix_fmt_sel`. Both outputs change only as a result of a completed write.
- R6: Writes to offsets 0x04 and 0x08 update only the bytes whose strobe is set.
- R7: Reads of offsets 0x00, 0x04 and 0x08 return the last value written to them. Reads of any other offset, including unaligned ones, return zero with an OKAY response. Writes to such offsets are answered with OKAY and change nothing.
- R8: The write address and write data may arrive in either order or in the same cycle. Exactly one OKAY write response follows, after both have been accepted, and it stays valid until `s_bready`. No new address or data is accepted while the response is pending.
- R9: Read data and `s_rvalid` stay stable until `s_rready` is seen. `s_arready` is low while a read response is pending.
- R10: `seq_rd_entry` shows the entry of the slot that was on `seq_rd_idx` at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous reset, active high |
| s_awaddr | input | 8 | Write address (byte offset) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 8 | Read address (byte offset) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| seq_rd_idx | input | 8 | Table slot requested by the sequencer |
| seq_rd_entry | output | 16 | Entry of that slot, one cycle later |
| seq_restart | output | 1 | Restart request to the sequencer |
| pix_fmt_sel | output | 3 | Colour format selector to the pixel decoder |

## Verification
The hardest case to reach from the ports is a write whose address and data handshakes are split across cycles in each of the two orders. Both halves must still be merged into one table write and one response. The stimulus runs the same table-load write three ways: both channels together, the address two cycles before the data, and the data two cycles before the address. After each, it reads the slot back through the sequencer port. Partial-strobe writes are followed straight away by a table read and a register read, so that a rejected write would show up at the ports.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  typedef enum logic [1:0] {
    SEL_LOAD    = 2'd0,
    SEL_RESTART = 2'd1,
    SEL_FORMAT  = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int unsigned NUM_REGS = 3;

endpackage

// File: rtl/cfgw_wr_join.sv
module cfgw_wr_join #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  output logic              fire,
  output logic [ADDR_W-1:0] fire_addr,
  output logic [DATA_W-1:0] fire_data,
  output logic [STRB_W-1:0] fire_strb
);

  logic              aw_held, w_held, bvalid_q, fire_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;

  assign awready = !aw_held && !bvalid_q;
  assign wready  = !w_held && !bvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_held  <= 1'b0;
      w_held   <= 1'b0;
      bvalid_q <= 1'b0;
      fire_q   <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      strb_q   <= '0;
    end else begin
      fire_q <= 1'b0;
      if (awvalid && awready) begin
        aw_held <= 1'b1;
        addr_q  <= awaddr;
      end
      if (wvalid && wready) begin
        w_held <= 1'b1;
        data_q <= wdata;
        strb_q <= wstrb;
      end
      if (aw_held && w_held) begin
        aw_held  <= 1'b0;
        w_held   <= 1'b0;
        fire_q   <= 1'b1;
        bvalid_q <= 1'b1;
      end
      if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  assign bvalid    = bvalid_q;
  assign fire      = fire_q;
  assign fire_addr = addr_q;
  assign fire_data = data_q;
  assign fire_strb = strb_q;

  // R8: response held until taken
  p_bvalid_hold_r8: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid);
  // R8: every register update comes with a response
  p_fire_has_resp_r8: assert property (@(posedge clk) disable iff (rst)
    fire |-> bvalid);
  // R8: nothing accepted while a response is pending
  p_no_accept_pending_r8: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> (!awready && !wready));

endmodule

// File: rtl/cfgw_rd_port.sv
module cfgw_rd_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic              rready,
  output logic [ADDR_W-1:0] look_addr,
  input  logic [DATA_W-1:0] look_data
);

  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign arready   = !rvalid_q;
  assign look_addr = araddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (arvalid && arready) begin
        rvalid_q <= 1'b1;
        rdata_q  <= look_data;
      end else if (rvalid_q && rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;

  // R9: read response stable until taken
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R9: no new read address while one is pending
  p_ar_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> !arready);

endmodule

// File: rtl/cfgw_table_ram.sv
module cfgw_table_ram #(
  parameter int IDX_W = 8,
  parameter int ENT_W = 16,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [ENT_W-1:0] rdata
);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rd_q <= mem[raddr];
  end

  assign rdata = rd_q;

endmodule

// File: rtl/sensor_cfg_slave.sv
module sensor_cfg_slave
  import cfgw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int ENT_W  = 16,
  parameter int FMT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic [IDX_W-1:0]  seq_rd_idx,
  output logic [ENT_W-1:0]  seq_rd_entry,
  output logic              seq_restart,
  output logic [FMT_W-1:0]  pix_fmt_sel
);

  localparam int STRB_W      = DATA_W / 8;
  localparam int FIELD_BYTES = (IDX_W + ENT_W + 7) / 8;
  localparam int WORD_W      = ADDR_W - 2;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    logic [WORD_W-1:0] word;
    word = a[ADDR_W-1:2];
    if (a[1:0] != 2'b00 || word >= WORD_W'(NUM_REGS)) begin
      return SEL_NONE;
    end
    return reg_sel_e'(word[1:0]);
  endfunction

  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  reg_sel_e          wr_sel;
  logic              field_ok;
  logic              tbl_we;

  cfgw_wr_join #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .awaddr    (s_awaddr),
    .awvalid   (s_awvalid),
    .awready   (s_awready),
    .wdata     (s_wdata),
    .wstrb     (s_wstrb),
    .wvalid    (s_wvalid),
    .wready    (s_wready),
    .bvalid    (s_bvalid),
    .bready    (s_bready),
    .fire      (wr_fire),
    .fire_addr (wr_addr),
    .fire_data (wr_data),
    .fire_strb (wr_strb)
  );

  assign s_bresp  = RESP_OKAY;
  assign wr_sel   = decode(wr_addr);
  assign field_ok = &wr_strb[FIELD_BYTES-1:0];
  assign tbl_we   = wr_fire && (wr_sel == SEL_LOAD) && field_ok;

  logic [DATA_W-1:0] ctl_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic reg_en;
    if (g == 0) begin : g_load
      assign reg_en = tbl_we;
    end else begin : g_plain
      assign reg_en = wr_fire && (wr_sel == reg_sel_e'(g));
    end
    for (genvar b = 0; b < STRB_W; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) begin
          ctl_q[g][b*8 +: 8] <= '0;
        end else if (reg_en && wr_strb[b]) begin
          ctl_q[g][b*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
    end
  end

  assign seq_restart = ctl_q[SEL_RESTART][0];
  assign pix_fmt_sel = ctl_q[SEL_FORMAT][FMT_W-1:0];

  cfgw_table_ram #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (wr_data[ENT_W +: IDX_W]),
    .wdata (wr_data[ENT_W-1:0]),
    .raddr (seq_rd_idx),
    .rdata (seq_rd_entry)
  );

  logic [ADDR_W-1:0] look_addr;
  logic [DATA_W-1:0] look_data;
  reg_sel_e          rd_sel;

  assign rd_sel = decode(look_addr);

  always_comb begin
    look_data = '0;
    if (rd_sel != SEL_NONE) begin
      look_data = ctl_q[rd_sel];
    end
  end

  cfgw_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .araddr    (s_araddr),
    .arvalid   (s_arvalid),
    .arready   (s_arready),
    .rdata     (s_rdata),
    .rvalid    (s_rvalid),
    .rready    (s_rready),
    .look_addr (look_addr),
    .look_data (look_data)
  );

  assign s_rresp = RESP_OKAY;

  // R4: table write enable is a single-cycle pulse
  p_tbl_we_single_r4: assert property (@(posedge clk) disable iff (rst)
    tbl_we |=> !tbl_we);
  // R5: control outputs move only after a completed write
  p_fmt_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> $stable(pix_fmt_sel));
  p_restart_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> $stable(seq_restart));
  // R3: load register holds unless the table is written
  p_load_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !tbl_we |=> $stable(ctl_q[SEL_LOAD]));

endmodule

// File: tb/sensor_cfg_slave_test.sv
module sensor_cfg_slave_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  s_awaddr = '0;
  logic        s_awvalid = 1'b0;
  logic        s_awready;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_wvalid = 1'b0;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready = 1'b0;
  logic [7:0]  s_araddr = '0;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready = 1'b0;
  logic [7:0]  seq_rd_idx = '0;
  logic [15:0] seq_rd_entry;
  logic        seq_restart;
  logic [2:0]  pix_fmt_sel;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_cfg_slave uut (
    .clk(clk), .rst(rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .seq_rd_idx(seq_rd_idx), .seq_rd_entry(seq_rd_entry),
    .seq_restart(seq_restart), .pix_fmt_sel(pix_fmt_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // mode 0: both together, 1: address first, 2: data first
  task automatic axi_write(input logic [7:0] a, input logic [31:0] d,
                           input logic [3:0] st, input int mode);
    bit aw_done = 0;
    bit w_done  = 0;
    int guard   = 0;
    int lag     = 0;
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = st;
    if (mode != 2) s_awvalid = 1'b1;
    if (mode != 1) s_wvalid  = 1'b1;
    while (!(aw_done && w_done) && guard < 50) begin
      bit aw_hs, w_hs;
      aw_hs = s_awvalid && s_awready;
      w_hs  = s_wvalid && s_wready;
      @(negedge clk);
      guard++;
      if (aw_hs) begin s_awvalid = 1'b0; aw_done = 1; end
      if (w_hs)  begin s_wvalid  = 1'b0; w_done  = 1; end
      if ((aw_done ^ w_done) && !s_awvalid && !s_wvalid) begin
        lag++;
        if (lag >= 2) begin
          if (!aw_done) s_awvalid = 1'b1;
          if (!w_done)  s_wvalid  = 1'b1;
        end
      end
    end
    guard = 0;
    while (!s_bvalid && guard < 20) begin @(negedge clk); guard++; end
    chk("R8 bvalid", {31'd0, s_bvalid}, 32'd1);
    chk("R8 bresp", {30'd0, s_bresp}, 32'd0);
    @(negedge clk);
    chk("R8 bvalid held", {31'd0, s_bvalid}, 32'd1);
    s_bready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0;
    chk("R8 single response", {31'd0, s_bvalid}, 32'd0);
  endtask

  task automatic axi_read(input logic [7:0] a, output logic [31:0] d);
    logic [31:0] first;
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    @(negedge clk);
    s_arvalid = 1'b0;
    chk("R9 rvalid", {31'd0, s_rvalid}, 32'd1);
    chk("R9 arready low", {31'd0, s_arready}, 32'd0);
    chk("R7 rresp", {30'd0, s_rresp}, 32'd0);
    first = s_rdata;
    @(negedge clk);
    chk("R9 rdata held", s_rdata, first);
    s_rready = 1'b1;
    @(negedge clk);
    s_rready = 1'b0;
    chk("R9 rvalid cleared", {31'd0, s_rvalid}, 32'd0);
    d = first;
  endtask

  task automatic peek(input logic [7:0] idx, output logic [15:0] e);
    @(negedge clk);
    seq_rd_idx = idx;
    @(negedge clk);
    e = seq_rd_entry;
  endtask

  task automatic t_reset;
    logic [31:0] r;
    chk("R1 restart", {31'd0, seq_restart}, 32'd0);
    chk("R1 format", {29'd0, pix_fmt_sel}, 32'd0);
    chk("R1 bvalid", {31'd0, s_bvalid}, 32'd0);
    chk("R1 rvalid", {31'd0, s_rvalid}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      axi_read(8'(i * 4), r);
      chk("R1 reg zero", r, 32'd0);
    end
  endtask

  task automatic t_table_orders;
    logic [15:0] e;
    logic [31:0] r;
    axi_write(8'h00, 32'hFF12_3A04, 4'hF, 0);
    axi_write(8'h00, 32'h0000_C9F0, 4'hF, 1);
    axi_write(8'h00, 32'h00FF_1E11, 4'hF, 2);
    axi_write(8'h00, 32'h0013_5566, 4'h7, 0);
    peek(8'h12, e); chk("R2 slot 0x12", {16'd0, e}, 32'h3A04);
    peek(8'h00, e); chk("R2 slot 0x00 addr-first", {16'd0, e}, 32'hC9F0);
    peek(8'hFF, e); chk("R2 slot 0xFF data-first", {16'd0, e}, 32'h1E11);
    peek(8'h13, e); chk("R2 slot 0x13", {16'd0, e}, 32'h5566);
    axi_read(8'h00, r); chk("R7 load readback", r, 32'h0013_5566);
  endtask

  task automatic t_overwrite;
    logic [15:0] e;
    axi_write(8'h00, 32'h0012_0101, 4'hF, 0);
    axi_write(8'h00, 32'h0012_0202, 4'hF, 2);
    peek(8'h12, e); chk("R4 last write wins", {16'd0, e}, 32'h0202);
    peek(8'h13, e); chk("R4 neighbour untouched", {16'd0, e}, 32'h5566);
    peek(8'h11, e);
    peek(8'h12, e); chk("R10 one-cycle latency", {16'd0, e}, 32'h0202);
  endtask

  task automatic t_partial;
    logic [15:0] e;
    logic [31:0] r;
    axi_write(8'h00, 32'h0012_7777, 4'b1011, 0);
    peek(8'h12, e); chk("R3 table kept", {16'd0, e}, 32'h0202);
    axi_read(8'h00, r); chk("R3 load reg kept", r, 32'h0012_0202);
    axi_write(8'h00, 32'h0040_8888, 4'b1110, 1);
    peek(8'h40, e);
    axi_write(8'h00, 32'h0040_1234, 4'hF, 0);
    peek(8'h40, e); chk("R3 then full write lands", {16'd0, e}, 32'h1234);
  endtask

  task automatic t_controls;
    logic [31:0] r;
    axi_write(8'h04, 32'h1, 4'hF, 0);
    chk("R5 restart set", {31'd0, seq_restart}, 32'd1);
    axi_write(8'h04, 32'h0, 4'hF, 2);
    chk("R5 restart cleared", {31'd0, seq_restart}, 32'd0);
    axi_write(8'h08, 32'h2, 4'hF, 1);
    chk("R5 format 2", {29'd0, pix_fmt_sel}, 32'd2);
    axi_write(8'h08, 32'hFFFF_FFF5, 4'hF, 0);
    chk("R5 format 5", {29'd0, pix_fmt_sel}, 32'd5);
    axi_write(8'h08, 32'h0000_0300, 4'b0010, 0);
    chk("R6 format byte0 kept", {29'd0, pix_fmt_sel}, 32'd5);
    axi_read(8'h08, r); chk("R6 byte merge", r, 32'hFFFF_03F5);
    axi_write(8'h04, 32'h0000_0001, 4'b1110, 0);
    chk("R6 restart byte kept", {31'd0, seq_restart}, 32'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] r;
    axi_write(8'h0C, 32'hDEAD_BEEF, 4'hF, 0);
    axi_write(8'h09, 32'h0000_0007, 4'hF, 0);
    axi_read(8'h0C, r); chk("R7 unmapped 0x0C", r, 32'd0);
    axi_read(8'h09, r); chk("R7 unaligned 0x09", r, 32'd0);
    axi_read(8'h40, r); chk("R7 unmapped 0x40", r, 32'd0);
    chk("R7 format unchanged", {29'd0, pix_fmt_sel}, 32'd5);
    axi_read(8'h08, r); chk("R7 reg2 unchanged", r, 32'hFFFF_03F5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_table_orders();
    t_overwrite();
    t_partial();
    t_controls();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule